// File: doc/BRIEF.md
# Register Rename Map with Branch Snapshots

This block is the mapping table of a register-renaming front end. It holds one 6-bit physical register number for every architectural register. A group of lookup ports translates source register names combinationally. A single update port installs a new mapping for a destination register, and that mapping becomes visible on the following cycle.

To recover quickly from a wrong branch guess, the block keeps four snapshot slots, each labelled with a branch tag. When a branch is taken, the front end asks for a snapshot, and the whole table is copied into a free slot on that clock edge. If the branch later turns out to be mispredicted, the live table is reloaded from its slot in one cycle. That same event discards every snapshot taken after it. A branch that resolves correctly just frees its slot.

The snapshot bits sit next to each live entry, as extra storage for that entry, and not in a separate memory. This keeps the save and restore wiring local to each entry. When no slot is free, a snapshot request is refused with a stall.

Top module: `rename_map_ckpt`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every entry, and all four slots are free, so a snapshot request raises no stall.
- R2: Each lookup port returns the current mapping of its architectural register with no clock delay. An update (`wr_en_i`) writes `wr_phys_i` into entry `wr_arch_i`. The lookup ports show the new value only after the next rising edge.
- R3: A snapshot request that is not stalled copies the whole table into the lowest-numbered free slot and labels the slot with `ckpt_tag_i`. The copy holds the table as it was before any update in the same cycle. That update still reaches the live table.
- R4: `ckpt_stall_o` is high, and nothing is captured, when a request arrives while all four slots are occupied or while a mispredict restore is being applied in the same cycle.
- R5: A resolution with `res_mispred_i` high whose tag matches an occupied slot reloads the entire live table from that slot. The reloaded table is visible from the next cycle.
- R6: A mispredict restore frees its own slot and every slot allocated after it. Slots allocated before it stay occupied.
- R7: A resolution with `res_mispred_i` low whose tag matches an occupied slot frees that slot and leaves the live table unchanged.
- R8: When an update and a mispredict restore fall in the same cycle, the restore wins and the update is dropped.
- R9: A resolution whose tag matches no occupied slot has no effect on the live table or on slot occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_arch_i | input | NUM_RD x 5 | Architectural register for each lookup port |
| rd_phys_o | output | NUM_RD x 6 | Current mapping for each lookup port |
| wr_en_i | input | 1 | Mapping update valid |
| wr_arch_i | input | 5 | Architectural register to update |
| wr_phys_i | input | 6 | New physical register number |
| ckpt_req_i | input | 1 | Take a snapshot for a taken branch |
| ckpt_tag_i | input | 4 | Tag of the branch being snapshotted |
| ckpt_stall_o | output | 1 | Snapshot request refused this cycle |
| res_valid_i | input | 1 | Branch resolution valid |
| res_mispred_i | input | 1 | Resolved branch was mispredicted |
| res_tag_i | input | 4 | Tag of the resolved branch |

## Verification
The bench pairs a snapshot with an update in the same cycle. A design that captured after the update would restore the wrong value for that entry. It fills all slots, frees a middle slot through a correct resolution, and reallocates that slot. Because the reused slot is the youngest, restoring an older branch must free it; a design that ordered slots by index would leave it occupied and stall too early or too late. It also drives an update together with a restore, and drives a resolution with an unknown tag. A design that let the write through, or acted on a stale tag, would leave a wrong mapping or a changed slot count, and the bench observes that through the lookup ports and the stall output.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  localparam int unsigned DEF_NUM_ARCH = 32;
  localparam int unsigned DEF_PHYS_W   = 6;
  localparam int unsigned DEF_NUM_RD   = 2;
  localparam int unsigned DEF_NUM_CKPT = 4;
  localparam int unsigned DEF_TAG_W    = 4;
endpackage

// File: rtl/rmap_entry.sv
module rmap_entry #(
  parameter int unsigned     PHYS_W = 6,
  parameter int unsigned     NUM_CKPT = 4,
  parameter logic [PHYS_W-1:0] INIT = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [PHYS_W-1:0]   wr_data_i,
  input  logic [NUM_CKPT-1:0] save_i,
  input  logic                rest_en_i,
  input  logic [NUM_CKPT-1:0] rest_oh_i,
  output logic [PHYS_W-1:0]   map_o
);
  logic [PHYS_W-1:0] map_q;
  logic [PHYS_W-1:0] shadow_q [NUM_CKPT];
  logic [PHYS_W-1:0] rest_val;

  always_comb begin
    rest_val = '0;
    for (int k = 0; k < NUM_CKPT; k++)
      rest_val |= shadow_q[k] & {PHYS_W{rest_oh_i[k]}};
  end

  // restore has priority over a same-cycle update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        map_q <= INIT;
    else if (rest_en_i) map_q <= rest_val;
    else if (wr_en_i)   map_q <= wr_data_i;
  end

  for (genvar k = 0; k < NUM_CKPT; k++) begin : g_shadow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        shadow_q[k] <= INIT;
      else if (save_i[k]) shadow_q[k] <= map_q;
    end

    AST_SHADOW_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      save_i[k] |=> shadow_q[k] == $past(map_q)); // R3
  end

  assign map_o = map_q;

  AST_RESTORE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rest_en_i |=> map_q == $past(rest_val)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !rest_en_i) |=> $stable(map_q)); // R7
endmodule

// File: rtl/rmap_slot_ctrl.sv
module rmap_slot_ctrl #(
  parameter int unsigned NUM_CKPT = 4,
  parameter int unsigned TAG_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ckpt_req_i,
  input  logic [TAG_W-1:0]    ckpt_tag_i,
  input  logic                res_valid_i,
  input  logic                res_mispred_i,
  input  logic [TAG_W-1:0]    res_tag_i,
  output logic                ckpt_stall_o,
  output logic [NUM_CKPT-1:0] save_oh_o,
  output logic                restore_en_o,
  output logic [NUM_CKPT-1:0] restore_oh_o
);
  logic [NUM_CKPT-1:0]             busy_q, busy_d;
  logic [NUM_CKPT-1:0][TAG_W-1:0]  tag_q;
  // older_q[a][b]: slot a was allocated before slot b
  logic [NUM_CKPT-1:0][NUM_CKPT-1:0] older_q;
  logic [NUM_CKPT-1:0] match, hit_oh, free_oh, kill, rel_oh;
  logic hit_any, free_any, full, alloc;

  always_comb begin
    match = '0; hit_oh = '0; free_oh = '0;
    hit_any = 1'b0; free_any = 1'b0;
    for (int k = 0; k < NUM_CKPT; k++) begin
      match[k] = busy_q[k] && (tag_q[k] == res_tag_i);
      if (match[k] && !hit_any) begin hit_oh[k] = 1'b1; hit_any = 1'b1; end
      if (!busy_q[k] && !free_any) begin free_oh[k] = 1'b1; free_any = 1'b1; end
    end
  end

  assign full         = &busy_q;
  assign restore_en_o = res_valid_i && res_mispred_i && hit_any;
  assign restore_oh_o = restore_en_o ? hit_oh : '0;
  assign rel_oh       = (res_valid_i && !res_mispred_i) ? hit_oh : '0;
  assign ckpt_stall_o = ckpt_req_i && (full || restore_en_o);
  assign alloc        = ckpt_req_i && !ckpt_stall_o;
  assign save_oh_o    = alloc ? free_oh : '0;

  always_comb begin
    for (int j = 0; j < NUM_CKPT; j++) begin
      kill[j] = restore_oh_o[j];
      for (int k = 0; k < NUM_CKPT; k++)
        kill[j] = kill[j] | (restore_oh_o[k] & older_q[k][j]);
    end
    busy_d = (busy_q & ~kill & ~rel_oh) | save_oh_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= '0;
      tag_q   <= '0;
      older_q <= '0;
    end else begin
      busy_q <= busy_d;
      for (int k = 0; k < NUM_CKPT; k++) begin
        if (save_oh_o[k]) begin
          tag_q[k]   <= ckpt_tag_i;
          older_q[k] <= '0;
          for (int j = 0; j < NUM_CKPT; j++)
            older_q[j][k] <= busy_q[j] & ~rel_oh[j];
        end
      end
    end
  end

  AST_SAVE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(save_oh_o)); // R3
  AST_STALL_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_stall_o |=> $countones(busy_q) <= $countones($past(busy_q))); // R4
  AST_RESTORE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_en_o |=> (busy_q & $past(restore_oh_o)) == '0); // R6
  AST_RESOLVE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_mispred_i && hit_any) |=> (busy_q & $past(hit_oh)) == '0); // R7
  AST_STALE_TAG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !hit_any && !ckpt_req_i) |=> busy_q == $past(busy_q)); // R9
endmodule

// File: rtl/rename_map_ckpt.sv
module rename_map_ckpt #(
  parameter int unsigned NUM_ARCH = rmap_pkg::DEF_NUM_ARCH,
  parameter int unsigned PHYS_W   = rmap_pkg::DEF_PHYS_W,
  parameter int unsigned NUM_RD   = rmap_pkg::DEF_NUM_RD,
  parameter int unsigned NUM_CKPT = rmap_pkg::DEF_NUM_CKPT,
  parameter int unsigned TAG_W    = rmap_pkg::DEF_TAG_W,
  localparam int unsigned AW      = $clog2(NUM_ARCH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_RD-1:0][AW-1:0]    rd_arch_i,
  output logic [NUM_RD-1:0][PHYS_W-1:0] rd_phys_o,
  input  logic                         wr_en_i,
  input  logic [AW-1:0]                wr_arch_i,
  input  logic [PHYS_W-1:0]            wr_phys_i,
  input  logic                         ckpt_req_i,
  input  logic [TAG_W-1:0]             ckpt_tag_i,
  output logic                         ckpt_stall_o,
  input  logic                         res_valid_i,
  input  logic                         res_mispred_i,
  input  logic [TAG_W-1:0]             res_tag_i
);
  logic [NUM_CKPT-1:0] save_oh, restore_oh;
  logic                restore_en;
  logic [PHYS_W-1:0]   map_w [NUM_ARCH];

  rmap_slot_ctrl #(.NUM_CKPT(NUM_CKPT), .TAG_W(TAG_W)) i_slot_ctrl (
    .clk_i, .rst_ni,
    .ckpt_req_i, .ckpt_tag_i,
    .res_valid_i, .res_mispred_i, .res_tag_i,
    .ckpt_stall_o,
    .save_oh_o    (save_oh),
    .restore_en_o (restore_en),
    .restore_oh_o (restore_oh)
  );

  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_entry
    rmap_entry #(.PHYS_W(PHYS_W), .NUM_CKPT(NUM_CKPT), .INIT(PHYS_W'(i))) i_entry (
      .clk_i, .rst_ni,
      .wr_en_i   (wr_en_i && (wr_arch_i == AW'(i))),
      .wr_data_i (wr_phys_i),
      .save_i    (save_oh),
      .rest_en_i (restore_en),
      .rest_oh_i (restore_oh),
      .map_o     (map_w[i])
    );
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rd_phys_o[r] = map_w[rd_arch_i[r]];
  end

  AST_STALL_ONLY_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_stall_o |-> ckpt_req_i); // R4
endmodule

// File: tb/test_rename_map_ckpt.sv
`timescale 1ns/1ps
module test_rename_map_ckpt;
  logic clk = 0, rst_n = 0;
  logic [1:0][4:0] rd_arch = '0;
  logic [1:0][5:0] rd_phys;
  logic wr_en = 0; logic [4:0] wr_arch = '0; logic [5:0] wr_phys = '0;
  logic ckpt_req = 0; logic [3:0] ckpt_tag = '0; logic ckpt_stall;
  logic res_valid = 0, res_mis = 0; logic [3:0] res_tag = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [5:0] exp_map [32];
  logic [5:0] snap [16][32];

  always #2.5 clk = ~clk;

  rename_map_ckpt i_rename_map_ckpt (
    .clk_i(clk), .rst_ni(rst_n), .rd_arch_i(rd_arch), .rd_phys_o(rd_phys),
    .wr_en_i(wr_en), .wr_arch_i(wr_arch), .wr_phys_i(wr_phys),
    .ckpt_req_i(ckpt_req), .ckpt_tag_i(ckpt_tag), .ckpt_stall_o(ckpt_stall),
    .res_valid_i(res_valid), .res_mispred_i(res_mis), .res_tag_i(res_tag));

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check_table(string req);
    for (int i = 0; i < 32; i += 2) begin
      rd_arch[0] = 5'(i); rd_arch[1] = 5'(i + 1);
      #0.1;
      chk(req, rd_phys[0], exp_map[i]);
      chk(req, rd_phys[1], exp_map[i + 1]);
    end
  endtask

  task automatic do_write(int a, int v);
    wr_en = 1; wr_arch = 5'(a); wr_phys = 6'(v);
    tick();
    wr_en = 0;
    exp_map[a] = 6'(v);
  endtask

  task automatic take_ckpt(int tag, bit exp_stall, string req);
    ckpt_req = 1; ckpt_tag = 4'(tag);
    #0.1;
    chk(req, ckpt_stall, exp_stall);
    if (!exp_stall) for (int i = 0; i < 32; i++) snap[tag][i] = exp_map[i];
    tick();
    ckpt_req = 0;
  endtask

  task automatic resolve(int tag, bit mis, bit hit);
    res_valid = 1; res_mis = mis; res_tag = 4'(tag);
    tick();
    res_valid = 0; res_mis = 0;
    if (mis && hit) for (int i = 0; i < 32; i++) exp_map[i] = snap[tag][i];
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i++) exp_map[i] = 6'(i);
    check_table("R1");
    ckpt_req = 1; #0.1;
    chk("R1", ckpt_stall, 0);
    ckpt_req = 0; #0.1;
  endtask

  task automatic t_update();
    wr_en = 1; wr_arch = 5; wr_phys = 40; rd_arch[0] = 5;
    #0.1;
    chk("R2", rd_phys[0], 5);          // not yet visible before the edge
    tick(); wr_en = 0; exp_map[5] = 40;
    do_write(31, 63);
    check_table("R2");
  endtask

  task automatic t_capture_order();
    // snapshot and update together: snapshot keeps the pre-update value
    ckpt_req = 1; ckpt_tag = 3; wr_en = 1; wr_arch = 5; wr_phys = 50;
    #0.1;
    chk("R3", ckpt_stall, 0);
    for (int i = 0; i < 32; i++) snap[3][i] = exp_map[i];
    tick(); ckpt_req = 0; wr_en = 0; exp_map[5] = 50;
    rd_arch[0] = 5; #0.1;
    chk("R3", rd_phys[0], 50);
    do_write(5, 12); do_write(7, 33);
    resolve(3, 1, 1);
    rd_arch[0] = 5; rd_arch[1] = 7; #0.1;
    chk("R3", rd_phys[0], 40);
    chk("R5", rd_phys[1], 7);
    check_table("R5");
  endtask

  task automatic t_full_and_age();
    for (int t = 1; t <= 4; t++) begin
      do_write(1, 10 + t);
      take_ckpt(t, 0, "R3");
    end
    do_write(1, 20);
    take_ckpt(9, 1, "R4");              // all slots busy
    resolve(2, 0, 1);                   // correct: frees slot, table kept
    check_table("R7");
    take_ckpt(5, 0, "R7");              // freed slot reused, now youngest
    take_ckpt(9, 1, "R4");
    do_write(2, 22);
    resolve(3, 1, 1);                   // frees 3,4,5; keeps 1
    check_table("R5");
    take_ckpt(6, 0, "R6");
    take_ckpt(7, 0, "R6");
    take_ckpt(8, 0, "R6");
    take_ckpt(9, 1, "R6");              // slot of tag 1 still held
    resolve(1, 1, 1);                   // oldest: frees everything
    check_table("R6");
    for (int t = 10; t <= 13; t++) take_ckpt(t, 0, "R6");
    take_ckpt(14, 1, "R4");
    resolve(10, 1, 1);
  endtask

  task automatic t_restore_wins();
    take_ckpt(2, 0, "R3");
    do_write(9, 44);
    res_valid = 1; res_mis = 1; res_tag = 2;
    wr_en = 1; wr_arch = 3; wr_phys = 55;
    ckpt_req = 1; ckpt_tag = 6;
    #0.1;
    chk("R4", ckpt_stall, 1);           // restore cycle refuses snapshot
    tick();
    res_valid = 0; res_mis = 0; wr_en = 0; ckpt_req = 0;
    for (int i = 0; i < 32; i++) exp_map[i] = snap[2][i];
    rd_arch[0] = 3; rd_arch[1] = 9; #0.1;
    chk("R8", rd_phys[0], exp_map[3]);
    chk("R8", rd_phys[1], exp_map[9]);
    check_table("R8");
  endtask

  task automatic t_stale_tag();
    take_ckpt(4, 0, "R3");
    do_write(11, 2);
    resolve(15, 1, 0);                  // no slot carries tag 15
    check_table("R9");
    resolve(15, 0, 0);
    for (int t = 0; t < 3; t++) take_ckpt(t, 0, "R9");
    take_ckpt(12, 1, "R9");             // occupancy unchanged: 4 held
    resolve(4, 1, 1);
    check_table("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_update();
    t_capture_order();
    t_full_and_age();
    t_restore_wins();
    t_stale_tag();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule